// File: doc/BRIEF.md
# Serial DAC Frame Shifter

This block feeds the serial interface of a group of analog DAC channels that share one framing line. Each phase-cycle tick loads a programmable strobe pattern, one sample word per channel and one inversion flag per channel. The block then moves one bit per DAC clock enable onto the strobe line and onto one data line per channel, most significant bit first. The strobe and data bits that belong to the same bit index appear together. A DAC clock output is derived from the same enable so that the converters can capture the bits.

A channel with its inversion flag set sends the bitwise complement of its sample. For a two's-complement word x, the converter receives -x-1, which reverses the sign of the analog output. Once all bits of a frame have gone out, the lines stay low until the next tick. A tick that arrives in the middle of a frame throws away the rest of that frame and starts a new one. Typical use is with the pattern 24'h7FFFC0, which holds the strobe high through bit 6 and low for the last six bits.

Top module: `dac_frame_shifter`

## Requirements
- R1: While rst_ni is low, and after its release until the first tick, strobe_o, data_o and dac_clk_o are all low.
- R2: After the clock edge that samples phase_tick_i high, strobe_o shows strobe_pat_i bit 23 and data_o[c] shows bit 23 of channel c's loaded word. Channel c's sample is taken from sample_i bits [24c+23:24c].
- R3: Each clock edge with dac_ce_i high and no tick advances all lines one bit toward bit 0, MSB first. Without an enable, the lines hold their value.
- R4: The 24th enable after a tick drives all strobe and data lines low. They then stay low, whatever dac_ce_i does, until the next tick.
- R5: A tick in the middle of a frame restarts at bit 23 with the newly latched words. The tick wins over an enable on the same edge.
- R6: With invert_i[c] high at the tick, the 24 bits sent on data_o[c] are the bitwise complement of the sample (equal to -x-1 in two's complement). With the flag low, they are the sample unchanged.
- R7: Channels are independent. Changes to sample_i, invert_i or strobe_pat_i between ticks have no effect on the frame in progress.
- R8: dac_clk_o is high in the cycle after each edge at which dac_ce_i is high, and low otherwise, whether or not a frame is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dac_ce_i | input | 1 | DAC bit-clock enable, one system cycle wide |
| phase_tick_i | input | 1 | Phase-cycle tick, loads a new frame |
| strobe_pat_i | input | 24 | Strobe pattern to send |
| sample_i | input | 96 | Sample words, channel c in bits [24c+23:24c] |
| invert_i | input | 4 | Per-channel data inversion flags |
| strobe_o | output | 1 | Serial strobe line |
| data_o | output | 4 | Serial data line per channel |
| dac_clk_o | output | 1 | DAC bit clock |

## Verification
The assertions assume that dac_ce_i and phase_tick_i are synchronous single-cycle pulses sampled on the system clock. They also assume that a frame counts as active only from a tick onward. The hold check further assumes that no enable or tick occurs in the cycle being compared. The stimulus drives every input on the falling edge, so each pulse spans exactly one rising edge. It runs frames with enable gaps of zero to two cycles, and it raises a tick together with an enable only in the restart test.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
  parameter int unsigned DFS_FRAME_W = 24;
  parameter int unsigned DFS_N_CH    = 4;
  parameter logic [DFS_FRAME_W-1:0] DFS_DEF_PAT = 24'h7FFFC0;
endpackage

// File: rtl/dfs_seq.sv
module dfs_seq #(
  parameter int unsigned W = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_i,
  input  logic tick_i,
  output logic load_o,
  output logic shift_o,
  output logic clear_o,
  output logic active_o
);
  localparam int unsigned CW = $clog2(W);

  logic [CW-1:0] cnt_q;
  logic          last;

  assign last    = (cnt_q == '0);
  assign load_o  = tick_i;
  assign shift_o = ce_i && active_o && !tick_i && !last;
  assign clear_o = ce_i && active_o && !tick_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_o <= 1'b0;
    end else if (load_o) begin
      cnt_q    <= CW'(W-1);
      active_o <= 1'b1;
    end else if (clear_o) begin
      active_o <= 1'b0;
    end else if (shift_o) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  p_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (active_o && cnt_q == CW'(W-1)));

  p_count_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && !tick_i && active_o && cnt_q != '0) |=> (active_o && cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/dfs_lane.sv
module dfs_lane #(
  parameter int unsigned W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  input  logic         clear_i,
  output logic         bit_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= load_val_i;
    else if (clear_i) sr_q <= '0;
    else if (shift_i) sr_q <= {sr_q[W-2:0], 1'b0};
  end

  assign bit_o = sr_q[W-1];
endmodule

// File: rtl/dfs_clk_gen.sv
module dfs_clk_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_i,
  output logic dac_clk_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dac_clk_o <= 1'b0;
    else         dac_clk_o <= ce_i;
  end

  p_clk_follow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i |=> dac_clk_o);
endmodule

// File: rtl/dac_frame_shifter.sv
module dac_frame_shifter
  import dfs_pkg::*;
#(
  parameter int unsigned FRAME_W = DFS_FRAME_W,
  parameter int unsigned N_CH    = DFS_N_CH
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    dac_ce_i,
  input  logic                    phase_tick_i,
  input  logic [FRAME_W-1:0]      strobe_pat_i,
  input  logic [N_CH*FRAME_W-1:0] sample_i,
  input  logic [N_CH-1:0]         invert_i,
  output logic                    strobe_o,
  output logic [N_CH-1:0]         data_o,
  output logic                    dac_clk_o
);
  logic load, shift, clear, active;

  dfs_seq #(.W(FRAME_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ce_i    (dac_ce_i),
    .tick_i  (phase_tick_i),
    .load_o  (load),
    .shift_o (shift),
    .clear_o (clear),
    .active_o(active)
  );

  dfs_lane #(.W(FRAME_W)) u_strobe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(strobe_pat_i),
    .shift_i   (shift),
    .clear_i   (clear),
    .bit_o     (strobe_o)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [FRAME_W-1:0] word;
    // complement at load so the shifter carries the word as sent
    assign word = sample_i[c*FRAME_W +: FRAME_W] ^ {FRAME_W{invert_i[c]}};

    dfs_lane #(.W(FRAME_W)) u_data (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (load),
      .load_val_i(word),
      .shift_i   (shift),
      .clear_i   (clear),
      .bit_o     (data_o[c])
    );
  end

  dfs_clk_gen u_clk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ce_i     (dac_ce_i),
    .dac_clk_o(dac_clk_o)
  );

  p_idle_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> (!strobe_o && data_o == '0));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !dac_ce_i && !phase_tick_i) |=> ($stable(strobe_o) && $stable(data_o)));
endmodule

// File: tb/sim_dac_frame_shifter.sv
module sim_dac_frame_shifter;
  localparam int W = 24;
  localparam int NC = 4;
  localparam int VW = W + NC*W + NC + 8;
  localparam int NV = 4;
  // {pattern, samples ch3..ch0, invert flags, enable gap}
  localparam logic [VW-1:0] VEC [NV] = '{
    {24'h7FFFC0, 24'h000001, 24'h800000, 24'h555555, 24'h123456, 4'b0000, 8'd0},
    {24'hA5A5A5, 24'hFFFFFF, 24'h000000, 24'h7FFFFF, 24'hC0FFEE, 4'b1010, 8'd1},
    {24'h000001, 24'h0F0F0F, 24'h000010, 24'hFEDCBA, 24'h3C3C3C, 4'b1111, 8'd2},
    {24'h800000, 24'h654321, 24'hAAAAAA, 24'h000002, 24'hFFFFFE, 4'b0101, 8'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b0, tick = 1'b0;
  logic [W-1:0] pat = '0;
  logic [NC*W-1:0] smp = '0;
  logic [NC-1:0] inv = '0;
  logic strobe;
  logic [NC-1:0] data;
  logic dclk;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dac_frame_shifter u0 (
    .clk_i(clk), .rst_ni(rst_n), .dac_ce_i(ce), .phase_tick_i(tick),
    .strobe_pat_i(pat), .sample_i(smp), .invert_i(inv),
    .strobe_o(strobe), .data_o(data), .dac_clk_o(dclk)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_word(input logic [NC*W-1:0] s, input logic [NC-1:0] f, input int c);
    return f[c] ? ~s[c*W +: W] : s[c*W +: W];
  endfunction

  // loads a frame and collects 24 bits; ce_tick raises an enable with the tick,
  // scramble alters every input right after the tick
  task automatic run_frame(input logic [W-1:0] p, input logic [NC*W-1:0] s, input logic [NC-1:0] f,
                           input int gap, input bit ce_tick, input bit scramble,
                           output logic [W-1:0] sw, output logic [NC-1:0][W-1:0] dw);
    @(negedge clk);
    pat = p; smp = s; inv = f; tick = 1'b1; ce = ce_tick;
    @(negedge clk);
    tick = 1'b0; ce = 1'b0;
    if (scramble) begin pat = ~p; smp = ~s; inv = ~f; end
    for (int b = W-1; b >= 0; b--) begin
      sw[b] = strobe;
      for (int c = 0; c < NC; c++) dw[c][b] = data[c];
      repeat (gap) @(negedge clk);
      ce = 1'b1;
      @(negedge clk);
      ce = 1'b0;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] sw;
    logic [NC-1:0][W-1:0] dw;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!strobe && data == '0 && !dclk, "R1 outputs in reset", {strobe, data, dclk}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!strobe && data == '0 && !dclk, "R1 outputs after reset", {strobe, data, dclk}, 0);

    // table: R2 R3 R6 R7 over varied patterns, flags and gaps
    for (int v = 0; v < NV; v++) begin
      logic [VW-1:0] e;
      e = VEC[v];
      run_frame(e[VW-1 -: W], e[VW-W-1 -: NC*W], e[11:8], int'(e[7:0]), 1'b0, 1'b0, sw, dw);
      chk(sw == e[VW-1 -: W], "R2 strobe word", sw, e[VW-1 -: W]);
      for (int c = 0; c < NC; c++)
        chk(dw[c] == exp_word(e[VW-W-1 -: NC*W], e[11:8], c), "R6 data word", dw[c],
            exp_word(e[VW-W-1 -: NC*W], e[11:8], c));
      chk(!strobe && data == '0, "R4 low after frame", {strobe, data}, 0);
    end

    // R4 enables while idle do nothing
    for (int k = 0; k < 5; k++) begin
      ce = 1'b1; @(negedge clk); ce = 1'b0; @(negedge clk);
      chk(!strobe && data == '0, "R4 idle under enable", {strobe, data}, 0);
    end

    // R3 hold without enable
    @(negedge clk);
    pat = 24'h800000; smp = {NC{24'h800000}}; inv = '0; tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    repeat (6) @(negedge clk);
    chk(strobe && data == '1, "R3 hold without enable", {strobe, data}, 5'h1F);
    ce = 1'b1; @(negedge clk); ce = 1'b0;
    chk(!strobe && data == '0, "R3 one enable one bit", {strobe, data}, 0);

    // R5 restart mid-frame with tick and enable together
    for (int k = 0; k < 9; k++) begin ce = 1'b1; @(negedge clk); ce = 1'b0; end
    run_frame(24'hC3A501, {24'h111111, 24'h222222, 24'h333333, 24'h444444}, 4'b0001,
              0, 1'b1, 1'b0, sw, dw);
    chk(sw == 24'hC3A501, "R5 restart strobe", sw, 24'hC3A501);
    chk(dw[0] == ~24'h444444, "R5 restart ch0", dw[0], ~24'h444444);
    chk(dw[3] == 24'h111111, "R5 restart ch3", dw[3], 24'h111111);

    // R7 inputs changed mid-frame are ignored
    run_frame(24'h7FFFC0, {24'h00ABCD, 24'h123000, 24'h0000FF, 24'h800001}, 4'b0110,
              0, 1'b0, 1'b1, sw, dw);
    chk(sw == 24'h7FFFC0, "R7 strobe kept", sw, 24'h7FFFC0);
    chk(dw[1] == ~24'h0000FF, "R7 ch1 kept", dw[1], ~24'h0000FF);
    chk(dw[3] == 24'h00ABCD, "R7 ch3 kept", dw[3], 24'h00ABCD);

    // R6 complement equals -x-1
    chk(W'(-$signed(24'h000010) - 1) == ~24'h000010, "R6 complement identity",
        ~24'h000010, W'(-$signed(24'h000010) - 1));

    // R8 DAC clock
    @(negedge clk); ce = 1'b1;
    @(posedge clk); #1;
    chk(dclk, "R8 clock high after enable", dclk, 1);
    @(negedge clk); ce = 1'b0;
    @(posedge clk); #1;
    chk(!dclk, "R8 clock low without enable", dclk, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule